// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block is the transmit side of an asynchronous serial port. The host drops a word into a one-entry holding stage. A shifter turns each word into a frame on the serial line: a start bit, eight or nine data bits and a stop bit. Each bit lasts for a programmable number of system clocks. The holding stage and the shifter work as a pair, so a second word can wait while the first is on the line, and consecutive frames leave with no idle time between them.

Two indicators pace the host. `hold_empty` means the holding stage can take another word. It rises when the waiting word moves into the shifter, which happens at the start of the stop bit of the frame in progress. `shift_empty` means no frame is on the line.

The block is built to close one known race. A host write can land in the same cycle as the bit-period overflow that ends a stop bit. In that case the written word is forwarded straight into the next frame, and an empty holding stage never produces a frame of its own.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `shift_empty` is 1.
- R2: A frame is one low start bit, then the data bits least significant bit first, then one high stop bit. Each bit lasts `divisor`+1 clocks. A single frame started from idle keeps `shift_empty` low for exactly (`divisor`+1)·(data bits+2) clocks, counted from the clock edge that accepts the write.
- R3: A `divisor` value of 0 or 1 behaves as 2, which gives a bit period of 3 clocks.
- R4: When `wide_mode` is 1, a frame carries 9 data bits, and the 9th bit is the value of `ninth_in` at the moment the word enters the shifter, not at the moment it was written. When `wide_mode` is 0, a frame carries 8 data bits.
- R5: A word that is waiting when a frame ends starts its own start bit on the clock right after that frame's stop bit, with no idle cycle in between.
- R6: A write while a frame is in progress clears `hold_empty` on the next clock. `hold_empty` returns to 1 at the first clock of that frame's stop bit.
- R7: `shift_empty` is 0 while a frame is on the line and 1 otherwise. The line is high whenever `shift_empty` is 1.
- R8: A write in the cycle where the final stop bit's period ends is sent as the very next frame, with no gap. Exactly one frame is added, and no all-zero frame appears.
- R9: Driving `enable` low aborts any frame, drops any waiting word, forces `txd` high and sets both empty indicators on the next clock. Writes are ignored while `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Port enable; low aborts and clears |
| wide_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| ninth_in | input | 1 | Source of the 9th data bit, sampled when a word enters the shifter |
| divisor | input | DIV_W | Bit period minus one, in clocks (minimum 2) |
| wr_en | input | 1 | Host write strobe for the holding stage |
| wr_data | input | DATA_W | Word written by the host |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding stage can accept a word |
| shift_empty | output | 1 | No frame is on the line |

## Verification
The bench builds the block with DATA_W=8 and DIV_W=4. That lets it sweep every divisor value from 0 to 15 in both frame widths, including the two clamped values. It also makes an exhaustive pass over all 256 eight-bit words streamed back to back, and over all 512 nine-bit words, affordable. The short bit periods put the stop-bit overflow at a cycle the bench computes exactly. A write can then be aimed at that cycle for several divisors and both widths.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_phase_e;

  localparam int unsigned MIN_DIV = 2;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  import sertx_pkg::*;

  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  // Clamp the divisor so a bit never lasts fewer than three clocks.
  assign lim  = (divisor < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : divisor;
  assign tick = run && (cnt_q >= lim);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: bit boundaries are at least three clocks apart.
  a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick ##1 !tick);

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              take,
  output logic              full,
  output logic              avail,
  output logic [DATA_W-1:0] src_word
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_ld;
  logic              bypass;

  // With the stage empty, a write taken in the same cycle is forwarded.
  assign bypass   = take && !full_q;
  assign avail    = full_q || wr_ok;
  assign src_word = full_q ? data_q : wr_word;
  assign full     = full_q;

  always_comb begin
    full_d  = full_q;
    data_ld = 1'b0;
    if (!enable) begin
      full_d = 1'b0;
    end else if (take) begin
      full_d  = full_q && wr_ok;
      data_ld = full_q && wr_ok;
    end else if (wr_ok) begin
      full_d  = 1'b1;
      data_ld = 1'b1;
    end
    data_d = data_ld ? wr_word : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_ld) data_q <= data_d;
  end

  // R6: a waiting word stays until the shifter takes it or the port closes.
  a_r6_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take && enable) |=> full_q);

  // R8: a forwarded write never leaves the stage marked full.
  a_r8_bypass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && enable) |=> !full_q);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              wide_mode,
  input  logic              ninth_in,
  input  logic              avail,
  input  logic [DATA_W-1:0] src_word,
  output logic              take,
  output logic              txd,
  output logic              idle
);
  import sertx_pkg::*;

  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  tx_phase_e          phase_q, phase_d;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic [CNT_W-1:0]   last_q, last_d;
  logic               pend_q, pend_d;
  logic               last_bit;
  logic               free;
  logic [FRAME_W-1:0] load_word;
  logic [CNT_W-1:0]   load_last;

  assign last_bit  = (bit_q == last_q);
  // The data register is free once the last data bit has gone out.
  assign free      = (phase_q == TX_IDLE)
                  || ((phase_q == TX_STOP) && !pend_q)
                  || ((phase_q == TX_DATA) && tick && last_bit);
  assign take      = enable && free && avail;
  assign load_word = {wide_mode ? ninth_in : 1'b0, src_word};
  assign load_last = wide_mode ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);

  always_comb begin
    phase_d = phase_q;
    sreg_d  = sreg_q;
    bit_d   = bit_q;
    last_d  = last_q;
    pend_d  = pend_q;
    if (!enable) begin
      phase_d = TX_IDLE;
      pend_d  = 1'b0;
    end else begin
      case (phase_q)
        TX_IDLE: begin
          if (take) begin
            phase_d = TX_START;
            sreg_d  = load_word;
            last_d  = load_last;
          end
        end
        TX_START: begin
          if (tick) begin
            phase_d = TX_DATA;
            bit_d   = '0;
          end
        end
        TX_DATA: begin
          if (tick) begin
            if (last_bit) begin
              phase_d = TX_STOP;
              if (take) begin
                sreg_d = load_word;
                last_d = load_last;
                pend_d = 1'b1;
              end
            end else begin
              sreg_d = sreg_q >> 1;
              bit_d  = bit_q + CNT_W'(1);
            end
          end
        end
        default: begin
          if (take) begin
            sreg_d = load_word;
            last_d = load_last;
            pend_d = 1'b1;
          end
          if (tick) begin
            pend_d  = 1'b0;
            phase_d = (pend_q || take) ? TX_START : TX_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= TX_IDLE;
      sreg_q  <= '0;
      bit_q   <= '0;
      last_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      sreg_q  <= sreg_d;
      bit_q   <= bit_d;
      last_q  <= last_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    case (phase_q)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sreg_q[0];
      default:  txd = 1'b1;
    endcase
  end

  assign idle = (phase_q == TX_IDLE);

  // R5: a word already waiting at the end of a stop bit starts a frame at once.
  a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase_q == TX_STOP && tick && pend_q) |=> phase_q == TX_START);

  // R2: the stop bit is always followed by a start bit or by idle.
  a_r2_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == TX_STOP && tick) |=> (phase_q == TX_START || phase_q == TX_IDLE));

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wide_mode,
  input  logic              ninth_in,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty
);

  logic [1:0]        rs_q;
  logic              rst_core_n;
  logic              wr_ok;
  logic              tick;
  logic              take;
  logic              full;
  logic              avail;
  logic              idle;
  logic [DATA_W-1:0] src_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign wr_ok = wr_en && enable;

  sertx_baud #(.DIV_W(DIV_W)) i_baud (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (enable && !idle),
    .divisor (divisor),
    .tick    (tick)
  );

  sertx_hold #(.DATA_W(DATA_W)) i_hold (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .enable   (enable),
    .wr_ok    (wr_ok),
    .wr_word  (wr_data),
    .take     (take),
    .full     (full),
    .avail    (avail),
    .src_word (src_word)
  );

  sertx_shift #(.DATA_W(DATA_W)) i_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .enable    (enable),
    .tick      (tick),
    .wide_mode (wide_mode),
    .ninth_in  (ninth_in),
    .avail     (avail),
    .src_word  (src_word),
    .take      (take),
    .txd       (txd),
    .idle      (idle)
  );

  assign hold_empty  = !full;
  assign shift_empty = idle;

  // R9: closing the port returns everything to the empty, idle-high state.
  a_r9_close: assert property (@(posedge clk) disable iff (!rst_core_n)
    !enable |=> (txd && hold_empty && shift_empty));

  // R7: the line never leaves high while no frame is in progress.
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_core_n)
    shift_empty |-> txd);

  // R8: a frame begins only for a real word, written or waiting.
  a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(shift_empty) |-> $past((wr_en && enable) || !hold_empty));

  // R5: a waiting word never sits behind an idle shifter.
  a_r5_drain: assert property (@(posedge clk) disable iff (!rst_core_n)
    (enable && !hold_empty && shift_empty) |=> !shift_empty);

endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int DIV_W      = 4;
  localparam int RX_MAX     = 2048;

  logic              clk;
  logic              rst_n;
  logic              enable;
  logic              wide_mode;
  logic              ninth_in;
  logic [DIV_W-1:0]  divisor;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              txd;
  logic              hold_empty;
  logic              shift_empty;

  sertx_top #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_sertx_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .wide_mode   (wide_mode),
    .ninth_in    (ninth_in),
    .divisor     (divisor),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // Line decoder settings
  int cur_p = 3;
  int cur_n = 8;
  bit mon_en = 1'b0;

  int       mcyc = 0;
  bit       busy = 1'b0;
  int       pos  = 0;
  int       fstart = 0;
  logic [8:0] word;
  bit       ferr;
  logic [8:0] rx_word [RX_MAX];
  int       rx_start [RX_MAX];
  bit       rx_ferr [RX_MAX];
  int       rx_count = 0;

  always @(negedge clk) begin
    mcyc = mcyc + 1;
    if (!mon_en) begin
      busy = 1'b0;
    end else if (!busy) begin
      if (txd === 1'b0) begin
        busy = 1'b1; pos = 0; fstart = mcyc; word = '0; ferr = 1'b0;
      end
    end else begin
      pos = pos + 1;
      if (pos % cur_p == cur_p / 2) begin
        int s;
        s = pos / cur_p;
        if (s == 0) begin
          if (txd !== 1'b0) ferr = 1'b1;
        end else if (s <= cur_n) begin
          word[s-1] = txd;
        end else begin
          if (txd !== 1'b1) ferr = 1'b1;
          if (rx_count < RX_MAX) begin
            rx_word[rx_count]  = word;
            rx_start[rx_count] = fstart;
            rx_ferr[rx_count]  = ferr;
          end
          rx_count = rx_count + 1;
          busy = 1'b0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic set_cfg(input int d, input bit mode);
    divisor   = DIV_W'(d);
    wide_mode = mode;
    cur_p     = ((d < 2) ? 2 : d) + 1;
    cur_n     = mode ? 9 : 8;
  endtask

  task automatic wr(input logic [8:0] v);
    wr_en    = 1'b1;
    wr_data  = v[7:0];
    ninth_in = v[8];
    @(negedge clk);
    wr_en    = 1'b0;
  endtask

  task automatic wait_idle(output int c);
    c = 0;
    while (!shift_empty && c < 5000) begin
      @(negedge clk);
      c++;
    end
  endtask

  // Write a word so that the accepting edge coincides with the stop-bit overflow.
  task automatic race(input int d, input bit mode, input logic [8:0] a, input logic [8:0] b);
    int base, f, c;
    set_cfg(d, mode);
    @(negedge clk);
    base = rx_count;
    f    = cur_p * (cur_n + 2);
    wr(a);
    repeat (f - 1) @(negedge clk);
    wr(b);
    check(hold_empty === 1'b1 && shift_empty === 1'b0, "R8 forwarded write",
          int'({hold_empty, shift_empty}), 2);
    wait_idle(c);
    repeat (3 * f) @(negedge clk);
    check(rx_count == base + 2, "R8 exactly one added frame", rx_count - base, 2);
    check(rx_word[base + 1] == b && !rx_ferr[base + 1], "R8 written word sent",
          int'(rx_word[base + 1]), int'(b));
    check(rx_start[base + 1] - rx_start[base] == f, "R8 no gap",
          rx_start[base + 1] - rx_start[base], f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1..all: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int c, base, bad, gaps, f;
    logic [8:0] exp;
    rst_n = 1'b0; enable = 1'b0; wide_mode = 1'b0; ninth_in = 1'b0;
    divisor = '0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1 txd", int'(txd), 1);
    check(hold_empty === 1'b1, "R1 hold_empty", int'(hold_empty), 1);
    check(shift_empty === 1'b1, "R1 shift_empty", int'(shift_empty), 1);
    enable = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);

    // R2, R3, R7: every divisor in both widths
    for (int d = 0; d < 16; d++) begin
      for (int m = 0; m < 2; m++) begin
        set_cfg(d, m[0]);
        @(negedge clk);
        base = rx_count;
        exp  = 9'((d * 37 + m * 101 + 'h5A) & (m ? 'h1FF : 'hFF));
        wr(exp);
        check(shift_empty === 1'b0, "R7 busy during frame", int'(shift_empty), 0);
        wait_idle(c);
        if (d < 2) check(c == cur_p * (cur_n + 2), "R3 clamped frame length", c, cur_p * (cur_n + 2));
        else       check(c == cur_p * (cur_n + 2), "R2 frame length", c, cur_p * (cur_n + 2));
        repeat (2) @(negedge clk);
        check(rx_count == base + 1 && rx_word[base] == exp && !rx_ferr[base], "R2 frame content",
              int'(rx_word[base]), int'(exp));
      end
    end

    // R5: all 256 bytes streamed back to back
    set_cfg(2, 1'b0);
    @(negedge clk);
    base = rx_count;
    for (int v = 0; v < 256; v++) begin
      while (!hold_empty) @(negedge clk);
      wr(9'(v));
    end
    wait_idle(c);
    repeat (4) @(negedge clk);
    check(rx_count == base + 256, "R5 stream count", rx_count - base, 256);
    bad = 0; gaps = 0;
    f = cur_p * (cur_n + 2);
    for (int v = 0; v < 256; v++) begin
      if (rx_word[base + v] != 9'(v) || rx_ferr[base + v]) bad++;
      if (v > 0 && rx_start[base + v] - rx_start[base + v - 1] != f) gaps++;
    end
    check(bad == 0, "R5 stream content", bad, 0);
    check(gaps == 0, "R5 back-to-back spacing", gaps, 0);

    // R4: all 512 nine-bit words
    set_cfg(2, 1'b1);
    @(negedge clk);
    base = rx_count;
    for (int v = 0; v < 512; v++) begin
      wr(9'(v));
      wait_idle(c);
    end
    repeat (4) @(negedge clk);
    bad = 0;
    for (int v = 0; v < 512; v++)
      if (rx_count < base + 512 || rx_word[base + v] != 9'(v)) bad++;
    check(bad == 0, "R4 nine-bit words", bad, 0);

    // R6: hold_empty timing
    set_cfg(3, 1'b0);
    @(negedge clk);
    base = rx_count;
    wr(9'h0C3);
    wr(9'h03C);
    c = 1;
    check(hold_empty === 1'b0, "R6 hold full after write", int'(hold_empty), 0);
    while (!hold_empty && c < 1000) begin
      @(negedge clk);
      c++;
    end
    check(c == cur_p * (cur_n + 1), "R6 empties at stop start", c, cur_p * (cur_n + 1));
    wait_idle(c);
    repeat (4) @(negedge clk);
    check(rx_count == base + 2 && rx_word[base + 1] == 9'h03C, "R6 held word sent",
          int'(rx_word[base + 1]), 'h3C);

    // R4: ninth bit sampled at transfer, not at write
    set_cfg(3, 1'b1);
    @(negedge clk);
    base = rx_count;
    wr(9'h1C3);
    ninth_in = 1'b0;
    wait_idle(c);
    repeat (4) @(negedge clk);
    check(rx_word[base] == 9'h1C3, "R4 sampled at idle load", int'(rx_word[base]), 'h1C3);
    base = rx_count;
    wr(9'h0A5);
    wr(9'h15A);
    ninth_in = 1'b0;
    wait_idle(c);
    repeat (4) @(negedge clk);
    check(rx_count == base + 2 && rx_word[base + 1] == 9'h05A, "R4 sampled at transfer",
          int'(rx_word[base + 1]), 'h05A);

    // R8: write on the stop-bit overflow, several configurations
    race(0, 1'b0, 9'h0FF, 9'h081);
    race(2, 1'b0, 9'h055, 9'h001);
    race(7, 1'b1, 9'h1AA, 9'h100);
    race(15, 1'b1, 9'h033, 9'h1FE);

    // R9: abort while busy with a waiting word
    set_cfg(3, 1'b0);
    @(negedge clk);
    wr(9'h033);
    wr(9'h044);
    repeat (10) @(negedge clk);
    enable = 1'b0;
    mon_en = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R9 line high", int'(txd), 1);
    check(hold_empty === 1'b1 && shift_empty === 1'b1, "R9 both empty",
          int'({hold_empty, shift_empty}), 3);
    wr(9'h077);
    @(negedge clk);
    check(shift_empty === 1'b1 && hold_empty === 1'b1, "R9 write ignored when closed",
          int'({hold_empty, shift_empty}), 3);
    enable = 1'b1;
    mon_en = 1'b1;
    base = rx_count;
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    check(bad == 0 && rx_count == base, "R9 no frame after reopen", bad, 0);
    wr(9'h03C);
    wait_idle(c);
    repeat (4) @(negedge clk);
    check(rx_count == base + 1 && rx_word[base] == 9'h03C, "R9 normal after reopen",
          int'(rx_word[base]), 'h3C);

    finished = 1'b1;
    report();
    $finish;
  end

endmodule